// File: doc/BRIEF.md
# Two-Window Memory Port Arbiter

This block shares one memory command port between a DMA requester and a CPU requester. Time is split into two windows that take turns: a DMA window and a CPU window. Each window has a length in clock cycles, set by software. While a window is open, its owner has first claim on the port. If the owner has nothing to send, the other side may borrow single bursts. Borrowing does not disturb the window timer.

Each window also has a two-bit yield policy. The policy says when a request from the other requester may close the window before its timer runs out. A window only ever changes hands between bursts. The grant is registered, and once given it stays on the same requester until that requester signals the end of its burst.

Top module: `win_arb`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `gnt` to 2'b00, opens the DMA window (`win_cpu` = 0) and loads the remaining-cycle count from `cfg_dma_len`.
- R2: `gnt` is never more than one-hot. Bit 0 grants DMA and bit 1 grants CPU. A grant appears on the clock edge after a burst boundary at which the requester's request was high.
- R3: A burst boundary is a cycle in which `gnt` is 2'b00, or the granted requester's done input is high. Away from a boundary, `gnt` and `win_cpu` hold their values. A done pulse from the requester that is not granted has no effect.
- R4: The remaining count drops by one each cycle and stops at zero. At a boundary where the count is zero, the window passes to the other requester and the count reloads from that requester's length. A length of 0 gives a window that is already expired.
- R5: At a boundary, after any window change, the grant goes to the window owner if it is requesting. Otherwise it goes to the other requester if that one is requesting (a borrow, which leaves the window and its count as they are). Otherwise no grant is given.
- R6: Policy code 2'd0 on the owner: the other requester never closes the window early.
- R7: Policy code 2'd3 on the owner: at any boundary where the other requester is requesting, the window passes to it.
- R8: Policy code 2'd1 on the owner: an early hand-over happens only at a boundary where the other requester is requesting and the remaining count is at most floor(length/2).
- R9: Policy code 2'd2 on the owner: an early hand-over happens only at a boundary where the other requester is requesting and the owner is not.
- R10: Window lengths are 8 bits wide. Values such as 20, 40 and 255 time the window exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_req | input | 1 | DMA requester wants the port |
| dma_burst_done | input | 1 | Last cycle of the DMA burst in progress |
| cpu_req | input | 1 | CPU requester wants the port |
| cpu_burst_done | input | 1 | Last cycle of the CPU burst in progress |
| cfg_dma_len | input | 8 | DMA window length in cycles |
| cfg_cpu_len | input | 8 | CPU window length in cycles |
| cfg_dma_pol | input | 2 | Yield policy of the DMA window |
| cfg_cpu_pol | input | 2 | Yield policy of the CPU window |
| gnt | output | 2 | Registered one-hot grant, bit 0 DMA, bit 1 CPU |
| win_cpu | output | 1 | Current window owner, 1 for CPU, 0 for DMA |

## Verification
The properties read the policy and length inputs in the same cycle they judge. They therefore assume these inputs describe the window currently running. The stimulus changes configuration only while reset is held. Done pulses and requests are driven freely, including done from the requester that is not granted, because the block must ignore those. The properties take no other constraint from the requesters.

// File: rtl/win_arb_pkg.sv
package win_arb_pkg;
  typedef enum logic {
    OWN_DMA = 1'b0,
    OWN_CPU = 1'b1
  } owner_e;

  localparam logic [1:0] POL_NEVER  = 2'd0;
  localparam logic [1:0] POL_HALF   = 2'd1;
  localparam logic [1:0] POL_IDLE   = 2'd2;
  localparam logic [1:0] POL_ALWAYS = 2'd3;

  localparam int unsigned N_PORTS = 2;
endpackage

// File: rtl/win_arb_policy.sv
module win_arb_policy
  import win_arb_pkg::*;
#(
  parameter int unsigned WIN_W = 8
) (
  input  logic [1:0]       pol,
  input  logic [WIN_W-1:0] remain,
  input  logic [WIN_W-1:0] len,
  input  logic             own_req,
  input  logic             rival_req,
  output logic             yield_ok
);
  logic allowed;

  always_comb begin
    unique case (pol)
      POL_NEVER:  allowed = 1'b0;
      POL_HALF:   allowed = (remain <= (len >> 1));
      POL_IDLE:   allowed = !own_req;
      POL_ALWAYS: allowed = 1'b1;
      default:    allowed = 1'b0;
    endcase
  end

  assign yield_ok = rival_req && allowed;
endmodule

// File: rtl/win_arb_timer.sv
module win_arb_timer #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] reset_len,
  input  logic             load,
  input  logic [WIN_W-1:0] load_len,
  output logic [WIN_W-1:0] remain,
  output logic             expired
);
  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= reset_len;
    else if (load)
      cnt_q <= load_len;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign remain  = cnt_q;
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/win_arb_grant.sv
module win_arb_grant
  import win_arb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boundary,
  input  logic [N_PORTS-1:0]  req,
  input  logic                next_owner,
  output logic [N_PORTS-1:0]  gnt
);
  logic [N_PORTS-1:0] gnt_q;
  logic [N_PORTS-1:0] gnt_d;
  logic [N_PORTS-1:0] own_hot;
  logic [N_PORTS-1:0] rival_hot;

  assign own_hot   = next_owner ? 2'b10 : 2'b01;
  assign rival_hot = next_owner ? 2'b01 : 2'b10;

  always_comb begin
    gnt_d = gnt_q;
    if (boundary) begin
      if (|(req & own_hot))
        gnt_d = own_hot;
      else if (|(req & rival_hot))
        gnt_d = rival_hot;
      else
        gnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      gnt_q <= '0;
    else
      gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/win_arb.sv
module win_arb
  import win_arb_pkg::*;
#(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_req,
  input  logic             dma_burst_done,
  input  logic             cpu_req,
  input  logic             cpu_burst_done,
  input  logic [WIN_W-1:0] cfg_dma_len,
  input  logic [WIN_W-1:0] cfg_cpu_len,
  input  logic [1:0]       cfg_dma_pol,
  input  logic [1:0]       cfg_cpu_pol,
  output logic [1:0]       gnt,
  output logic             win_cpu
);
  logic [N_PORTS-1:0] req;
  logic [N_PORTS-1:0] done;
  logic [N_PORTS-1:0] yield_ok;
  logic [WIN_W-1:0]   len_of  [N_PORTS];
  logic [1:0]         pol_of  [N_PORTS];
  logic [WIN_W-1:0]   remain;
  logic               expired;
  logic               boundary;
  logic               switch_win;
  owner_e             owner_q;
  owner_e             owner_d;
  logic [N_PORTS-1:0] gnt_w;

  assign req       = {cpu_req, dma_req};
  assign done      = {cpu_burst_done, dma_burst_done};
  assign len_of[0] = cfg_dma_len;
  assign len_of[1] = cfg_cpu_len;
  assign pol_of[0] = cfg_dma_pol;
  assign pol_of[1] = cfg_cpu_pol;

  // A boundary: no burst running, or the granted side ends its burst now.
  assign boundary = (gnt_w == '0) || (|(gnt_w & done));

  generate
    for (genvar p = 0; p < N_PORTS; p++) begin : g_pol
      win_arb_policy #(.WIN_W(WIN_W)) u_policy (
        .pol       (pol_of[p]),
        .remain    (remain),
        .len       (len_of[p]),
        .own_req   (req[p]),
        .rival_req (req[N_PORTS-1-p]),
        .yield_ok  (yield_ok[p])
      );
    end
  endgenerate

  assign switch_win = boundary && (expired || yield_ok[owner_q]);
  assign owner_d    = switch_win ? owner_e'(~owner_q) : owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      owner_q <= OWN_DMA;
    else
      owner_q <= owner_d;
  end

  win_arb_timer #(.WIN_W(WIN_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_len (cfg_dma_len),
    .load      (switch_win),
    .load_len  (len_of[owner_d]),
    .remain    (remain),
    .expired   (expired)
  );

  win_arb_grant u_grant (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .req        (req),
    .next_owner (owner_d),
    .gnt        (gnt_w)
  );

  assign gnt     = gnt_w;
  assign win_cpu = (owner_q == OWN_CPU);
endmodule

// File: rtl/win_arb_chk.sv
module win_arb_chk #(
  parameter int unsigned WIN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_req,
  input logic             dma_burst_done,
  input logic             cpu_req,
  input logic             cpu_burst_done,
  input logic [1:0]       cfg_dma_pol,
  input logic [1:0]       cfg_cpu_pol,
  input logic [1:0]       gnt,
  input logic             win_cpu,
  input logic [WIN_W-1:0] remain
);
  logic at_edge;
  assign at_edge = (gnt == 2'b00) || (gnt[0] && dma_burst_done) || (gnt[1] && cpu_burst_done);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r2_dma_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt[0] && !dma_req) |=> !gnt[0]);

  a_r2_cpu_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt[1] && !cpu_req) |=> !gnt[1]);

  a_r3_hold_dma_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && !dma_burst_done) |=> gnt[0]);

  a_r3_hold_cpu_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[1] && !cpu_burst_done) |=> gnt[1]);

  a_r3_window_mid_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !at_edge |=> $stable(win_cpu));

  a_r6_dma_never: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_cpu && cfg_dma_pol == 2'd0 && remain != '0) |=> !win_cpu);

  a_r6_cpu_never: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cpu && cfg_cpu_pol == 2'd0 && remain != '0) |=> win_cpu);

  a_r7_dma_always: assert property (@(posedge clk) disable iff (!rst_n)
    (at_edge && !win_cpu && cfg_dma_pol == 2'd3 && cpu_req) |=> win_cpu);

  a_r7_cpu_always: assert property (@(posedge clk) disable iff (!rst_n)
    (at_edge && win_cpu && cfg_cpu_pol == 2'd3 && dma_req) |=> !win_cpu);

  a_r9_dma_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_cpu && cfg_dma_pol == 2'd2 && dma_req && remain != '0) |=> !win_cpu);
endmodule

bind win_arb win_arb_chk #(.WIN_W(WIN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dma_req        (dma_req),
  .dma_burst_done (dma_burst_done),
  .cpu_req        (cpu_req),
  .cpu_burst_done (cpu_burst_done),
  .cfg_dma_pol    (cfg_dma_pol),
  .cfg_cpu_pol    (cfg_cpu_pol),
  .gnt            (gnt),
  .win_cpu        (win_cpu),
  .remain         (remain)
);

// File: tb/win_arb_tb.sv
module win_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_req = 1'b0, dma_burst_done = 1'b0;
  logic       cpu_req = 1'b0, cpu_burst_done = 1'b0;
  logic [7:0] cfg_dma_len = 8'd20, cfg_cpu_len = 8'd40;
  logic [1:0] cfg_dma_pol = 2'd0, cfg_cpu_pol = 2'd0;
  logic [1:0] gnt;
  logic       win_cpu;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int m_own = 0;   // 0 DMA window, 1 CPU window
  int m_rem = 20;
  int m_g   = 0;   // 0 none, 1 DMA, 2 CPU

  always #2.5 clk = ~clk;

  win_arb u_dut (
    .clk(clk), .rst_n(rst_n),
    .dma_req(dma_req), .dma_burst_done(dma_burst_done),
    .cpu_req(cpu_req), .cpu_burst_done(cpu_burst_done),
    .cfg_dma_len(cfg_dma_len), .cfg_cpu_len(cfg_cpu_len),
    .cfg_dma_pol(cfg_dma_pol), .cfg_cpu_pol(cfg_cpu_pol),
    .gnt(gnt), .win_cpu(win_cpu)
  );

  function automatic int req_of(int who);
    return (who == 0) ? int'(dma_req) : int'(cpu_req);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_own = 0; m_rem = int'(cfg_dma_len); m_g = 0;
    end else begin
      bit free;
      free = (m_g == 0) || (m_g == 1 && dma_burst_done) || (m_g == 2 && cpu_burst_done);
      if (free) begin
        int len, pol, rival;
        bit may, flip;
        rival = 1 - m_own;
        len = (m_own == 0) ? int'(cfg_dma_len) : int'(cfg_cpu_len);
        pol = (m_own == 0) ? int'(cfg_dma_pol) : int'(cfg_cpu_pol);
        may = (pol == 3) || (pol == 1 && m_rem <= len / 2) ||
              (pol == 2 && req_of(m_own) == 0);
        flip = (m_rem == 0) || (req_of(rival) != 0 && may);
        if (flip) begin
          m_own = rival;
          m_rem = (m_own == 0) ? int'(cfg_dma_len) : int'(cfg_cpu_len);
        end else if (m_rem > 0) m_rem--;
        if (req_of(m_own) != 0) m_g = m_own + 1;
        else if (req_of(1 - m_own) != 0) m_g = 2 - m_own;
        else m_g = 0;
      end else if (m_rem > 0) m_rem--;
    end
  end

  task automatic check(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", r, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    int eg;
    eg = (m_g == 1) ? 1 : (m_g == 2) ? 2 : 0;
    check(tag, int'(gnt), eg, "gnt");
    check(tag, int'(win_cpu), m_own, "win_cpu");
  end

  task automatic segment(string r, int dl, int cl, int dp, int cp,
                         int pd, int pc, int pdone, int n);
    @(negedge clk);
    rst_n = 1'b0; tag = "R1";
    cfg_dma_len = dl[7:0]; cfg_cpu_len = cl[7:0];
    cfg_dma_pol = dp[1:0]; cfg_cpu_pol = cp[1:0];
    dma_req = 0; cpu_req = 0; dma_burst_done = 0; cpu_burst_done = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(gnt), 0, "reset gnt");
    check("R1", int'(win_cpu), 0, "reset window");
    rst_n = 1'b1; tag = r;
    for (int i = 0; i < n; i++) begin
      dma_req        = ($urandom % 100) < pd;
      cpu_req        = ($urandom % 100) < pc;
      dma_burst_done = ($urandom % 100) < pdone;
      cpu_burst_done = ($urandom % 100) < pdone;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(7));
    repeat (2) @(negedge clk);
    // R2: directed first grant one edge after the request
    segment("R2", 20, 40, 0, 0, 0, 0, 0, 1);
    dma_req = 1; cpu_req = 0;
    @(negedge clk);
    check("R2", int'(gnt), 1, "first dma grant");
    segment("R6", 20, 40, 0, 0, 70, 70, 30, 2500);
    segment("R7", 20, 40, 3, 3, 60, 60, 40, 2500);
    segment("R8", 30, 30, 1, 1, 70, 70, 35, 2500);
    segment("R9", 40, 20, 2, 2, 50, 50, 35, 2500);
    segment("R5", 40, 20, 0, 0, 15, 80, 40, 2500);
    segment("R3", 20, 20, 1, 2, 80, 80, 10, 2500);
    segment("R4", 0, 3, 0, 0, 50, 50, 50, 1500);
    segment("R10", 255, 1, 0, 3, 70, 70, 30, 3000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule